// File: doc/BRIEF.md
# Legacy Memory Window Decoder

This block sits on the host side of a memory controller. For every access whose 20-bit address falls in the region from 0xA0000 to 0xFFFFF, it decides whether the access is served by system DRAM or passed on to the expansion bus. Accesses below 0xA0000 belong to other logic, and the block asserts neither select for them.

The region is made of three parts:

- **Video window (0xA0000–0xBFFFF).** This window goes to DRAM only when a management-RAM control byte allows it. That byte is combined with a system-management-mode input.
- **Twelve 16 KB expansion segments (0xC0000–0xEFFFF).** Each segment has its own 2-bit attribute.
- **One 64 KB top segment (0xF0000–0xFFFFF).** This segment also has a single 2-bit attribute.

Software programs the attributes through a 32-bit configuration port with byte enables. The same port also holds a byte that records the installed memory size.

The select decision is combinational. It is computed from the stored configuration bytes, the access strobes and the management-mode input. A configuration write therefore changes the decode from the cycle after its clock edge. A change on the management-mode input changes the decode in the same cycle.

Top module: `legwin_decoder`

## Requirements
- R1: After reset the memory-size byte (offset 0x57) and the seven attribute bytes (offsets 0x59–0x5F) read 0x00, and the management-RAM control byte (offset 0x72) reads 0x02. With these values every valid access in 0xA0000–0xFFFFF selects the bus.
- R2: The segment 0xF0000–0xFFFFF takes its attribute from bits 5:4 of offset 0x59.
- R3: Expansion segment i (0 to 11) covers 0xC0000 + i·0x4000 up to, but not including, the start of segment i+1. It takes its attribute from offset 0x5A + i/2: bits 1:0 when i is even, bits 5:4 when i is odd.
- R4: In an attribute, bit 0 sends reads to DRAM and bit 1 sends writes to DRAM. This gives 3 = both to DRAM, 1 = reads to DRAM and writes to the bus, 2 = writes to DRAM and reads to the bus, 0 = both to the bus.
- R5: A valid access to 0xA0000–0xBFFFF selects DRAM when either of these holds; otherwise it selects the bus:
  - bit 6 of offset 0x72 is set;
  - the management-mode input is high and bit 3 of offset 0x72 is set.
- R6: A change on the management-mode input changes the video-window decode in the same cycle, with no clock edge in between.
- R7: A configuration write takes effect from the cycle after the clock edge that accepts it. Only bytes whose enable is set change. Byte lane k of a dword at offset D carries offset D+k.
- R8: When the access strobe is low, or the address is below 0xA0000, neither select is asserted.
- R9: A valid access in 0xA0000–0xFFFFF asserts exactly one of the two selects.
- R10: Once bit 4 of offset 0x72 is set, bits 6 and 4 of that byte ignore writes until reset. The other bits of the byte stay writable.
- R11: Offsets 0x57, 0x59–0x5F and 0x72 read back as written, subject to R10. Every other offset reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address; bits 1:0 are ignored (dword access) |
| cfg_be | input | 4 | Byte enables for the write; lane k is offset cfg_addr[7:2]*4 + k |
| cfg_wdata | input | 32 | Write data; lane k in bits 8k+7:8k |
| cfg_rdata | output | 32 | Combinational read data for the addressed dword |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | The access is a write (1) or a read (0) |
| acc_addr | input | 20 | Access address |
| smm_active | input | 1 | System-management mode is active |
| sel_dram | output | 1 | Access is served by DRAM |
| sel_bus | output | 1 | Access is forwarded to the expansion bus |

## Verification
The only state in this block is the configuration bytes. A corrupted attribute shows at the ports in two ways: through the read-back value, and as a flipped select for the one segment and direction that read that field. Because of this, the bench compares the selects and the read data against its model on every cycle, so a wrong stored bit is reported in the cycle it first matters. The bench sweeps the first and last address of each segment with both reads and writes after each attribute change, so a misplaced nibble or segment boundary shows within that sweep. Lock and byte-enable errors are exposed by reading back the affected byte right after the write.

// File: rtl/legwin_pkg.sv
// Package: shared types, constants and helpers for the legacy window decoder.
// Assumes a 20-bit address space; boundaries below are fixed by the memory map.
package legwin_pkg;

    // Region an access address falls in.
    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_VIDEO = 2'd1,
        RGN_EXP   = 2'd2,
        RGN_TOP   = 2'd3
    } region_e;

    typedef logic [1:0] attr_t;

    // Bit positions within the management-RAM control byte.
    localparam int SMR_OPEN_BIT  = 6;
    localparam int SMR_LOCK_BIT  = 4;
    localparam int SMR_SMMEN_BIT = 3;

    // Bits frozen by the lock.
    localparam logic [7:0] SMR_LOCK_MASK = 8'h50;

    // Attribute bit 0 grants reads to DRAM, bit 1 grants writes.
    function automatic logic attr_grants(attr_t a, logic is_write);
        return is_write ? a[1] : a[0];
    endfunction

endpackage

// File: rtl/legwin_cfg_regs.sv
// Module: configuration byte store for the legacy window decoder.
// Holds the memory-size byte, the attribute bytes and the management-RAM
// control byte. Dword access with byte enables. Reads are combinational.
// Writes land on the clock edge. Assumes all offsets fit in CFG_AW bits.
module legwin_cfg_regs
    import legwin_pkg::*;
#(
    parameter int              CFG_AW    = 8,
    parameter int              ATTR_REGS = 7,
    parameter logic [CFG_AW-1:0] ATTR_BASE = 8'h59,
    parameter logic [CFG_AW-1:0] TOM_OFS   = 8'h57,
    parameter logic [CFG_AW-1:0] SMR_OFS   = 8'h72,
    parameter logic [7:0]      TOM_RST   = 8'h00,
    parameter logic [7:0]      SMR_RST   = 8'h02
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CFG_AW-1:0]             addr,
    input  logic [3:0]                    be,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    output logic [ATTR_REGS-1:0][7:0]     attr_q,
    output logic [7:0]                    smr_q
);

    localparam int LANES = 4;

    logic [7:0]                  tom_q;
    logic [LANES-1:0][CFG_AW-1:0] lane_ofs;
    logic [LANES-1:0][7:0]        lane_rd;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            // Byte offset carried by this lane.
            assign lane_ofs[ln] = {addr[CFG_AW-1:2], 2'(ln)};

            // Read mux: pick the stored byte for this lane's offset, else zero.
            always_comb begin
                lane_rd[ln] = 8'h00;
                if (lane_ofs[ln] == TOM_OFS) lane_rd[ln] = tom_q;
                if (lane_ofs[ln] == SMR_OFS) lane_rd[ln] = smr_q;
                for (int k = 0; k < ATTR_REGS; k++) begin
                    if (lane_ofs[ln] == ATTR_BASE + CFG_AW'(k)) lane_rd[ln] = attr_q[k];
                end
            end
        end
    endgenerate

    assign rdata = lane_rd;

    // Register update: reset values, then enabled-lane writes with lock merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tom_q  <= TOM_RST;
            smr_q  <= SMR_RST;
            attr_q <= '0;
        end else if (wr_en) begin
            for (int ln = 0; ln < LANES; ln++) begin
                if (be[ln]) begin
                    if (lane_ofs[ln] == TOM_OFS) tom_q <= wdata[8*ln +: 8];
                    if (lane_ofs[ln] == SMR_OFS) begin
                        if (smr_q[SMR_LOCK_BIT])
                            smr_q <= (wdata[8*ln +: 8] & ~SMR_LOCK_MASK) | (smr_q & SMR_LOCK_MASK);
                        else
                            smr_q <= wdata[8*ln +: 8];
                    end
                    for (int k = 0; k < ATTR_REGS; k++) begin
                        if (lane_ofs[ln] == ATTR_BASE + CFG_AW'(k)) attr_q[k] <= wdata[8*ln +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/legwin_seg_lookup.sv
// Module: classifies an access address into a legacy region and picks the
// 2-bit attribute of its segment. Assumes attribute byte 0 serves the top
// segment and bytes 1.. serve the expansion segments, two per byte.
module legwin_seg_lookup
    import legwin_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int ATTR_REGS    = 7,
    parameter int SEG_SHIFT    = 14,
    parameter int NUM_EXP_SEGS = 12
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ATTR_REGS-1:0][7:0] attr_q,
    output region_e                   region,
    output attr_t                     attr
);

    localparam logic [ADDR_W-1:0] VIDEO_LO = ADDR_W'(20'hA0000);
    localparam logic [ADDR_W-1:0] EXP_LO   = ADDR_W'(20'hC0000);
    localparam logic [ADDR_W-1:0] TOP_LO   = ADDR_W'(20'hF0000);
    localparam int                IDX_W    = ADDR_W - SEG_SHIFT;
    localparam logic [IDX_W-1:0]  EXP_IDX0 = EXP_LO[ADDR_W-1:SEG_SHIFT];

    attr_t [NUM_EXP_SEGS-1:0] seg_attr;
    logic  [IDX_W-1:0]        seg_idx;
    attr_t                    exp_attr;
    logic                     unused_bits;

    generate
        for (genvar s = 0; s < NUM_EXP_SEGS; s++) begin : g_seg
            // Segment s reads the low nibble of its byte when even, high when odd.
            assign seg_attr[s] = attr_q[1 + s/2][(s%2)*4 +: 2];
        end
    endgenerate

    assign seg_idx = addr[ADDR_W-1:SEG_SHIFT] - EXP_IDX0;

    // Expansion attribute mux, guarded against out-of-table indices.
    always_comb begin
        exp_attr = '0;
        for (int s = 0; s < NUM_EXP_SEGS; s++) begin
            if (seg_idx == IDX_W'(s)) exp_attr = seg_attr[s];
        end
    end

    // Region classification and attribute selection.
    always_comb begin
        region = RGN_NONE;
        attr   = '0;
        if (addr >= TOP_LO) begin
            region = RGN_TOP;
            attr   = attr_q[0][5:4];
        end else if (addr >= EXP_LO) begin
            region = RGN_EXP;
            attr   = exp_attr;
        end else if (addr >= VIDEO_LO) begin
            region = RGN_VIDEO;
        end
    end

    assign unused_bits = ^{attr_q, addr[SEG_SHIFT-1:0]};

endmodule

// File: rtl/legwin_route.sv
// Module: turns region, attribute, access direction and management state
// into the DRAM / bus selects. Purely combinational; assumes region and
// attr come from the segment lookup in the same cycle.
module legwin_route
    import legwin_pkg::*;
(
    input  region_e    region,
    input  attr_t      attr,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       smm_active,
    input  logic [7:0] smr_q,
    output logic       sel_dram,
    output logic       sel_bus
);

    logic grant;
    logic claimed;
    logic unused_bits;

    // DRAM grant per region.
    always_comb begin
        unique case (region)
            RGN_VIDEO:       grant = smr_q[SMR_OPEN_BIT] | (smm_active & smr_q[SMR_SMMEN_BIT]);
            RGN_EXP, RGN_TOP: grant = attr_grants(attr, acc_write);
            default:         grant = 1'b0;
        endcase
    end

    assign claimed  = acc_valid & (region != RGN_NONE);
    assign sel_dram = claimed & grant;
    assign sel_bus  = claimed & ~grant;

    assign unused_bits = ^{smr_q[7], smr_q[5:4], smr_q[2:0]};

endmodule

// File: rtl/legwin_decoder.sv
// Module: top of the legacy memory window decoder. Joins the configuration
// store, the segment lookup and the routing stage. The decode is
// combinational from stored bytes and the access/management inputs.
module legwin_decoder
    import legwin_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int CFG_AW    = 8,
    parameter int ATTR_REGS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              smm_active,
    output logic              sel_dram,
    output logic              sel_bus
);

    logic [ATTR_REGS-1:0][7:0] attr_q;
    logic [7:0]                smr_q;
    region_e                   region;
    attr_t                     attr;

    legwin_cfg_regs #(
        .CFG_AW    (CFG_AW),
        .ATTR_REGS (ATTR_REGS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .addr   (cfg_addr),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .attr_q (attr_q),
        .smr_q  (smr_q)
    );

    legwin_seg_lookup #(
        .ADDR_W    (ADDR_W),
        .ATTR_REGS (ATTR_REGS)
    ) u_lookup (
        .addr   (acc_addr),
        .attr_q (attr_q),
        .region (region),
        .attr   (attr)
    );

    legwin_route u_route (
        .region     (region),
        .attr       (attr),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .smm_active (smm_active),
        .smr_q      (smr_q),
        .sel_dram   (sel_dram),
        .sel_bus    (sel_bus)
    );

endmodule

// File: rtl/legwin_checker.sv
// Module: property checker for legwin_decoder, attached by bind below.
// Observes ports plus the stored control bytes.
module legwin_checker #(
    parameter int ADDR_W    = 20,
    parameter int ATTR_REGS = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_wr_en,
    input logic                          acc_valid,
    input logic [ADDR_W-1:0]             acc_addr,
    input logic                          smm_active,
    input logic                          sel_dram,
    input logic                          sel_bus,
    input logic [7:0]                    smr_q,
    input logic [ATTR_REGS-1:0][7:0]     attr_q
);

    logic in_region;
    logic in_video;
    assign in_region = acc_addr >= ADDR_W'(20'hA0000);
    assign in_video  = in_region && (acc_addr < ADDR_W'(20'hC0000));

    // R8: no select outside the region or without a strobe
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || !in_region) |-> (!sel_dram && !sel_bus));

    // R9: exactly one select for a claimed access
    assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_region) |-> $onehot({sel_dram, sel_bus}));

    // R5: video window open bit forces DRAM
    assert_video_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_video && smr_q[6]) |-> sel_dram);

    // R5: management mode with its enable bit opens the window
    assert_video_smm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_video && smm_active && smr_q[3]) |-> sel_dram);

    // R5: both paths closed forwards to the bus
    assert_video_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_video && !smr_q[6] && !(smm_active && smr_q[3])) |-> sel_bus);

    // R10: once locked, the lock and open bits hold
    assert_lock_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smr_q[4] |=> (smr_q[4] && (smr_q[6] == $past(smr_q[6]))));

    // R7: without a write strobe, the decode bytes do not move
    assert_no_write_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(smr_q) && $stable(attr_q)));

endmodule

bind legwin_decoder legwin_checker #(
    .ADDR_W    (ADDR_W),
    .ATTR_REGS (ATTR_REGS)
) u_legwin_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .smm_active (smm_active),
    .sel_dram   (sel_dram),
    .sel_bus    (sel_bus),
    .smr_q      (smr_q),
    .attr_q     (attr_q)
);

// File: tb/legwin_decoder_test.sv
// Bench: behavioural reference model of the configuration bytes and the
// decode, compared against the design at every falling clock edge.
module legwin_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        acc_valid;
    logic        acc_write;
    logic [19:0] acc_addr;
    logic        smm_active;
    logic        sel_dram;
    logic        sel_bus;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit finished   = 0;
    string req     = "R1";

    // Reference byte store: only implemented offsets are ever non-zero.
    byte unsigned mem [256];

    legwin_decoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .smm_active (smm_active),
        .sel_dram   (sel_dram),
        .sel_bus    (sel_bus)
    );

    always #5 clk = ~clk;

    function automatic bit implemented(int ofs);
        return (ofs == 'h57) || (ofs >= 'h59 && ofs <= 'h5F) || (ofs == 'h72);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem['h72] = 8'h02;
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            model_reset();
        end else if (cfg_wr_en) begin
            for (int k = 0; k < 4; k++) begin
                int ofs;
                byte unsigned nb;
                ofs = int'({cfg_addr[7:2], 2'b00}) + k;
                nb  = cfg_wdata[8*k +: 8];
                if (cfg_be[k] && implemented(ofs)) begin
                    if (ofs == 'h72 && mem['h72][4])
                        nb = (nb & 8'hAF) | (mem['h72] & 8'h50);
                    mem[ofs] = nb;
                end
            end
        end
    endtask

    task automatic expected(output bit d, output bit b);
        int a;
        int at;
        a  = int'(acc_addr);
        d  = 0;
        b  = 0;
        at = -1;
        if (acc_valid && a >= 'hA0000) begin
            if (a < 'hC0000) begin
                d = mem['h72][6] || (smm_active && mem['h72][3]);
            end else begin
                if (a >= 'hF0000) at = (mem['h59] >> 4) & 3;
                for (int i = 0; i < 12; i++)
                    if (a >= 'hC0000 + i*'h4000 && a < 'hC0000 + (i+1)*'h4000)
                        at = (mem['h5A + i/2] >> ((i%2)*4)) & 3;
                d = acc_write ? at[1] : at[0];
            end
            b = !d;
        end
    endtask

    task automatic compare();
        bit d, b;
        logic [31:0] er;
        int base;
        expected(d, b);
        compared++;
        if (sel_dram !== d || sel_bus !== b) begin
            mismatched++;
            $display("FAIL %s sel addr=%h wr=%0b: actual dram=%b bus=%b expected dram=%b bus=%b",
                     req, acc_addr, acc_write, sel_dram, sel_bus, d, b);
        end
        base = int'({cfg_addr[7:2], 2'b00});
        er = {mem[base+3], mem[base+2], mem[base+1], mem[base]};
        compared++;
        if (cfg_rdata !== er) begin
            mismatched++;
            $display("FAIL %s rdata ofs=%h: actual %h expected %h", req, base, cfg_rdata, er);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        cycles++;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr_en = 1'b1;
        tick();
        cfg_wr_en = 1'b0;
        tick();
    endtask

    task automatic access(input logic [19:0] a, input logic wr);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        tick();
    endtask

    task automatic sweep_all();
        for (int s = 0; s < 14; s++) begin
            logic [19:0] lo, hi;
            if (s < 12) begin lo = 20'hC0000 + 20'(s*'h4000); hi = lo + 20'h3FFF; end
            else if (s == 12) begin lo = 20'hF0000; hi = 20'hFFFFF; end
            else begin lo = 20'hA0000; hi = 20'hBFFFF; end
            access(lo, 1'b0); access(lo, 1'b1); access(hi, 1'b0); access(hi, 1'b1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = 8'h00; cfg_be = 4'h0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; smm_active = 1'b0;
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;

        // R1: reset contents and default forwarding
        req = "R1";
        cfg_addr = 8'h54; tick();
        cfg_addr = 8'h58; tick();
        cfg_addr = 8'h5C; tick();
        cfg_addr = 8'h70; tick();
        sweep_all();

        // R2: top segment attribute in bits 5:4 of offset 0x59
        req = "R2";
        for (int v = 0; v < 4; v++) begin
            cfg_write(8'h58, 4'b0010, 32'(v << 12) | 32'h0000_0F00);
            access(20'hF0000, 1'b0); access(20'hF8000, 1'b1); access(20'hFFFFF, 1'b0);
            access(20'hEFFFF, 1'b0);
        end

        // R3 + R4: each expansion segment alone, with each encoding
        req = "R3";
        for (int s = 0; s < 12; s++) begin
            for (int v = 1; v < 4; v++) begin
                logic [7:0] ofs;
                int lane;
                cfg_write(8'h58, 4'b1110, 32'h0);
                cfg_write(8'h5C, 4'b1111, 32'h0);
                ofs  = 8'(8'h5A + s/2);
                lane = int'(ofs[1:0]);
                cfg_write({ofs[7:2], 2'b00}, 4'(1 << lane),
                          32'(v << ((s%2)*4)) << (8*lane));
                req = "R4";
                sweep_all();
                req = "R3";
            end
        end

        // R5 + R6: video window control and management-mode input
        req = "R5";
        for (int v = 0; v < 4; v++) begin
            cfg_write(8'h70, 4'b0100, 32'(((v & 1) << 3) | ((v >> 1) << 6)) << 16);
            for (int m = 0; m < 2; m++) begin
                smm_active = 1'(m);
                access(20'hA0000, 1'b0); access(20'hBFFFF, 1'b1);
            end
        end
        req = "R6";
        cfg_write(8'h70, 4'b0100, 32'h0008_0000);
        acc_valid = 1'b1; acc_addr = 20'hB0000; acc_write = 1'b0;
        for (int i = 0; i < 6; i++) begin
            smm_active = ~smm_active;
            #1;
            compared++;
            if (sel_dram !== smm_active) begin
                mismatched++;
                $display("FAIL R6 same-cycle smm: actual dram=%b expected %b", sel_dram, smm_active);
            end
            tick();
        end
        smm_active = 1'b0;

        // R7: partial byte enables touch only enabled lanes
        req = "R7";
        cfg_write(8'h5C, 4'b1111, 32'h0);
        cfg_write(8'h5C, 4'b0101, 32'hFFFF_FFFF);
        sweep_all();
        cfg_write(8'h54, 4'b1000, 32'hA500_0000);
        cfg_addr = 8'h54; tick();

        // R8: no strobe, or below the region
        req = "R8";
        cfg_write(8'h58, 4'b1110, 32'hFFFF_FF00);
        cfg_write(8'h70, 4'b0100, 32'h0040_0000);
        acc_valid = 1'b0; acc_addr = 20'hC0000; tick();
        acc_addr = 20'hA0000; tick();
        access(20'h9FFFF, 1'b0); access(20'h00000, 1'b1); access(20'h0C000, 1'b0);

        // R9: claimed accesses across the region
        req = "R9";
        sweep_all();

        // R10: lock freezes bits 6 and 4 until reset
        req = "R10";
        cfg_write(8'h70, 4'b0100, 32'h0050_0000);
        cfg_write(8'h70, 4'b0100, 32'h0008_0000);
        cfg_addr = 8'h70; tick();
        access(20'hA0000, 1'b0);
        cfg_write(8'h70, 4'b0100, 32'h00A7_0000);
        cfg_addr = 8'h70; tick();
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        cfg_write(8'h70, 4'b0100, 32'h0000_0000);
        cfg_addr = 8'h70; tick();
        access(20'hA0000, 1'b0);

        // R11: unimplemented offsets read zero and ignore writes
        req = "R11";
        cfg_write(8'h60, 4'b1111, 32'hDEAD_BEEF);
        cfg_addr = 8'h60; tick();
        cfg_write(8'h00, 4'b1111, 32'h1234_5678);
        cfg_addr = 8'h00; tick();
        cfg_write(8'h54, 4'b1111, 32'hFFFF_FFFF);
        cfg_addr = 8'h54; tick();
        cfg_addr = 8'hFC; tick();

        // R4: mixed random traffic
        req = "R4";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            cfg_wr_en = (r == 0);
            cfg_addr  = 8'($urandom_range(0, 255));
            if (r == 1) cfg_addr = 8'h58 + 8'(4 * $urandom_range(0, 1));
            if (r == 0 && $urandom_range(0, 1) == 1) cfg_addr = 8'h58;
            cfg_be     = 4'($urandom);
            cfg_wdata  = $urandom;
            acc_valid  = 1'($urandom);
            acc_write  = 1'($urandom);
            acc_addr   = 20'h80000 + 20'($urandom_range(0, 'h7FFFF));
            smm_active = 1'($urandom);
            if (i == 2000) rst_n = 1'b0;
            if (i == 2002) rst_n = 1'b1;
            tick();
        end
        cfg_wr_en = 1'b0;
        tick();

        finish_run();
    end

endmodule